// File: doc/BRIEF.md
# Eight-Line General-Purpose I/O Bank with Address-Masked Data and Pin Interrupts

This block is a bank of general-purpose I/O lines behind a simple word-addressed register port. Software sets each line as an input or an output, and reads or writes line values through a data window. In that window the address itself carries a per-line mask, so one line can be changed without a read-modify-write. The line values leave the block on `pin_out`, and the direction settings leave on `pin_oe` for the pad ring. Incoming line levels pass through a two-stage synchronizer before any logic uses them.

Each line can raise an interrupt. The trigger is chosen per line: a level or an edge, one edge or both edges, and the active polarity. Edge events are latched until software clears them. Level conditions follow the synchronized line and are not latched. A per-line enable gates each line's status into one registered interrupt output. Raw and enabled status can both be read back.

Register access uses a byte address. Address bits [11:10] select the bank. In bank 0 (the data window, 0x000 to 0x3FC), bits [9:2] form the line mask. In bank 1, bits [4:2] select a control register. A read returns its value on `rd_data` at the clock edge after the request.

Top module: `gpio_bank`

## Requirements
- R1: A write to the data window (address bits [11:10] = 0) changes only the data bits whose mask bit (address bit 2+i for line i) is 1. Writes to any other bank leave `pin_out` unchanged.
- R2: A read of the data window returns 0 in every bit position whose mask bit is 0.
- R3: Control offset 0x400 is the direction register. Bit i = 1 makes line i an output, and `pin_oe` mirrors this register. A data read returns the data register bit for output lines and the synchronized line value for input lines. `pin_out` always shows the data register.
- R4: After reset, the data, direction, sense (0x404), both-edge (0x408), polarity (0x40C) and enable (0x410) registers are all zero. `irq` is 0 and `rd_data` is 0.
- R5: When a sense bit is 1, the line is level-sensitive. With polarity 1 the raw status (read at 0x414) equals the synchronized line. With polarity 0 it equals the inverse. The raw status drops again when the level goes away.
- R6: When a sense bit is 0 and its both-edge bit is 0, a rising edge sets the latched raw status if polarity is 1, and a falling edge sets it if polarity is 0. The opposite edge does not set it. The status stays set until cleared.
- R7: When a sense bit is 0 and its both-edge bit is 1, either edge sets the latched status, whatever the polarity bit holds.
- R8: The enabled status (read at 0x418) is raw status AND enable. `irq` is 1 exactly one cycle after any enabled status bit is 1.
- R9: Writing 1 to a bit at the clear offset 0x41C clears that line's latched edge status. Writing 0 leaves it unchanged. The clear offset reads as zero.
- R10: If an edge event and a clear for the same line fall in the same cycle, the status stays set.
- R11: A change on `pin_in` is not visible to a data read captured at the first clock edge after the change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Register access request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 12 | Byte address |
| req_wdata | input | 32 | Write data |
| rd_data | output | 32 | Read data, registered |
| pin_in | input | 8 | Asynchronous line inputs |
| pin_out | output | 8 | Line output values (data register) |
| pin_oe | output | 8 | Line output enables (direction register) |
| irq | output | 1 | Combined registered interrupt |

## Verification
Two functions can act in the same cycle: the edge detector latching a new event, and a software clear of that line's status. The bench provokes this overlap on purpose. It toggles a line at a falling clock edge and counts the two synchronizer stages, then places the clear write so that it is captured at the same rising edge where the detector sees the edge. The status is then read back and must still be set. A later plain clear must drop it. Constrained-random traffic mixes masked data writes, direction changes, trigger reconfiguration, line toggles and clears. All of it is judged against a bench model of the register contents and the latched edges.

// File: rtl/gpio_bank_pkg.sv
`timescale 1ns/1ps
package gpio_bank_pkg;
  // Bank selector taken from the two address bits above the mask field
  typedef enum logic [1:0] {
    BANK_DATA = 2'd0,
    BANK_CTRL = 2'd1
  } bank_e;

  // Control register index taken from address bits [4:2]
  typedef enum logic [2:0] {
    CSR_OUTEN = 3'd0,
    CSR_SENSE = 3'd1,
    CSR_BOTH  = 3'd2,
    CSR_POL   = 3'd3,
    CSR_ENA   = 3'd4,
    CSR_RAW   = 3'd5,
    CSR_MSK   = 3'd6,
    CSR_CLR   = 3'd7
  } csr_sel_e;

  localparam int WORD_LSB = 2;
endpackage

// File: rtl/gpio_bank_sync.sv
`timescale 1ns/1ps
module gpio_bank_sync #(
  parameter int WIDTH  = 8,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] async_in,
  output logic [WIDTH-1:0] sync_out
);
  logic [WIDTH-1:0] stage_q [STAGES];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int s = 0; s < STAGES; s++) stage_q[s] <= '0;
    end else begin
      stage_q[0] <= async_in;
      for (int s = 1; s < STAGES; s++) stage_q[s] <= stage_q[s-1];
    end
  end

  assign sync_out = stage_q[STAGES-1];
endmodule

// File: rtl/gpio_bank_irq.sv
`timescale 1ns/1ps
module gpio_bank_irq #(
  parameter int NUM_PINS = 8
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [NUM_PINS-1:0] line_s,
  input  logic [NUM_PINS-1:0] sense_lvl,
  input  logic [NUM_PINS-1:0] both_edge,
  input  logic [NUM_PINS-1:0] pol_hi,
  input  logic [NUM_PINS-1:0] enable,
  input  logic [NUM_PINS-1:0] clr_bits,
  output logic [NUM_PINS-1:0] evt,
  output logic [NUM_PINS-1:0] edge_st,
  output logic [NUM_PINS-1:0] raw_st,
  output logic [NUM_PINS-1:0] msk_st
);
  logic [NUM_PINS-1:0] prev_q;

  always_ff @(posedge clk) begin
    if (rst) prev_q <= '0;
    else     prev_q <= line_s;
  end

  for (genvar g = 0; g < NUM_PINS; g++) begin : g_line
    logic rise, fall, hit;
    assign rise = line_s[g] & ~prev_q[g];
    assign fall = ~line_s[g] & prev_q[g];
    assign hit  = both_edge[g] ? (rise | fall) : (pol_hi[g] ? rise : fall);
    assign evt[g] = ~sense_lvl[g] & hit;

    // A new event has priority over a clear in the same cycle
    always_ff @(posedge clk) begin
      if (rst)              edge_st[g] <= 1'b0;
      else if (evt[g])      edge_st[g] <= 1'b1;
      else if (clr_bits[g]) edge_st[g] <= 1'b0;
    end

    assign raw_st[g] = sense_lvl[g] ? (pol_hi[g] ? line_s[g] : ~line_s[g])
                                    : edge_st[g];
    assign msk_st[g] = raw_st[g] & enable[g];
  end
endmodule

// File: rtl/gpio_bank_regs.sv
`timescale 1ns/1ps
module gpio_bank_regs
  import gpio_bank_pkg::*;
#(
  parameter int NUM_PINS = 8,
  parameter int ADDR_W   = 12,
  parameter int DATA_W   = 32
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                req_valid,
  input  logic                req_write,
  input  logic [ADDR_W-1:0]   req_addr,
  input  logic [DATA_W-1:0]   req_wdata,
  input  logic [NUM_PINS-1:0] line_s,
  input  logic [NUM_PINS-1:0] raw_st,
  input  logic [NUM_PINS-1:0] msk_st,
  output logic [NUM_PINS-1:0] data_q,
  output logic [NUM_PINS-1:0] outen_q,
  output logic [NUM_PINS-1:0] sense_q,
  output logic [NUM_PINS-1:0] both_q,
  output logic [NUM_PINS-1:0] pol_q,
  output logic [NUM_PINS-1:0] ena_q,
  output logic [NUM_PINS-1:0] clr_bits,
  output logic [DATA_W-1:0]   rd_data
);
  localparam int BANK_LSB = WORD_LSB + NUM_PINS;
  localparam int SEL_W    = 3;

  logic [NUM_PINS-1:0] mask;
  bank_e               bank;
  csr_sel_e            sel;
  logic                wr_data, wr_ctrl, rd_req;
  logic [NUM_PINS-1:0] wbits;
  logic [NUM_PINS-1:0] view;
  logic [NUM_PINS-1:0] rd_next;
  logic                unused_bits;

  assign mask    = req_addr[BANK_LSB-1:WORD_LSB];
  assign bank    = bank_e'(req_addr[BANK_LSB+1:BANK_LSB]);
  assign sel     = csr_sel_e'(req_addr[WORD_LSB+SEL_W-1:WORD_LSB]);
  assign wbits   = req_wdata[NUM_PINS-1:0];
  assign wr_data = req_valid & req_write & (bank == BANK_DATA);
  assign wr_ctrl = req_valid & req_write & (bank == BANK_CTRL);
  assign rd_req  = req_valid & ~req_write;
  assign unused_bits = ^{req_wdata, req_addr};

  // Per-line data bits, each gated by its own address mask bit
  for (genvar g = 0; g < NUM_PINS; g++) begin : g_data
    always_ff @(posedge clk) begin
      if (rst)                     data_q[g] <= 1'b0;
      else if (wr_data && mask[g]) data_q[g] <= wbits[g];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      outen_q <= '0;
      sense_q <= '0;
      both_q  <= '0;
      pol_q   <= '0;
      ena_q   <= '0;
    end else if (wr_ctrl) begin
      case (sel)
        CSR_OUTEN: outen_q <= wbits;
        CSR_SENSE: sense_q <= wbits;
        CSR_BOTH:  both_q  <= wbits;
        CSR_POL:   pol_q   <= wbits;
        CSR_ENA:   ena_q   <= wbits;
        default:   ;
      endcase
    end
  end

  assign clr_bits = (wr_ctrl && sel == CSR_CLR) ? wbits : '0;

  assign view = (outen_q & data_q) | (~outen_q & line_s);

  always_comb begin
    rd_next = '0;
    if (bank == BANK_DATA) begin
      rd_next = view & mask;
    end else if (bank == BANK_CTRL) begin
      case (sel)
        CSR_OUTEN: rd_next = outen_q;
        CSR_SENSE: rd_next = sense_q;
        CSR_BOTH:  rd_next = both_q;
        CSR_POL:   rd_next = pol_q;
        CSR_ENA:   rd_next = ena_q;
        CSR_RAW:   rd_next = raw_st;
        CSR_MSK:   rd_next = msk_st;
        default:   rd_next = '0;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst)         rd_data <= '0;
    else if (rd_req) rd_data <= {{(DATA_W-NUM_PINS){1'b0}}, rd_next};
  end
endmodule

// File: rtl/gpio_bank.sv
`timescale 1ns/1ps
module gpio_bank #(
  parameter int NUM_PINS    = 8,
  parameter int ADDR_W      = 12,
  parameter int DATA_W      = 32,
  parameter int SYNC_STAGES = 2
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                req_valid,
  input  logic                req_write,
  input  logic [ADDR_W-1:0]   req_addr,
  input  logic [DATA_W-1:0]   req_wdata,
  output logic [DATA_W-1:0]   rd_data,
  input  logic [NUM_PINS-1:0] pin_in,
  output logic [NUM_PINS-1:0] pin_out,
  output logic [NUM_PINS-1:0] pin_oe,
  output logic                irq
);
  logic [NUM_PINS-1:0] line_s;
  logic [NUM_PINS-1:0] data_q, outen_q, sense_q, both_q, pol_q, ena_q;
  logic [NUM_PINS-1:0] clr_bits, evt, edge_st, raw_st, msk_st;
  logic                irq_q;

  gpio_bank_sync #(.WIDTH(NUM_PINS), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst), .async_in(pin_in), .sync_out(line_s)
  );

  gpio_bank_regs #(.NUM_PINS(NUM_PINS), .ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_regs (
    .clk(clk), .rst(rst),
    .req_valid(req_valid), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata),
    .line_s(line_s), .raw_st(raw_st), .msk_st(msk_st),
    .data_q(data_q), .outen_q(outen_q), .sense_q(sense_q),
    .both_q(both_q), .pol_q(pol_q), .ena_q(ena_q),
    .clr_bits(clr_bits), .rd_data(rd_data)
  );

  gpio_bank_irq #(.NUM_PINS(NUM_PINS)) u_irq (
    .clk(clk), .rst(rst), .line_s(line_s),
    .sense_lvl(sense_q), .both_edge(both_q), .pol_hi(pol_q),
    .enable(ena_q), .clr_bits(clr_bits),
    .evt(evt), .edge_st(edge_st), .raw_st(raw_st), .msk_st(msk_st)
  );

  always_ff @(posedge clk) begin
    if (rst) irq_q <= 1'b0;
    else     irq_q <= |msk_st;
  end

  assign irq     = irq_q;
  assign pin_out = data_q;
  assign pin_oe  = outen_q;
endmodule

// File: rtl/gpio_bank_chk.sv
`timescale 1ns/1ps
module gpio_bank_chk #(
  parameter int NUM_PINS = 8,
  parameter int ADDR_W   = 12
) (
  input logic                clk,
  input logic                rst,
  input logic                req_valid,
  input logic                req_write,
  input logic [ADDR_W-1:0]   req_addr,
  input logic [NUM_PINS-1:0] pin_out,
  input logic [NUM_PINS-1:0] pin_oe,
  input logic                irq,
  input logic [NUM_PINS-1:0] ena_q,
  input logic [NUM_PINS-1:0] clr_bits,
  input logic [NUM_PINS-1:0] evt,
  input logic [NUM_PINS-1:0] edge_st
);
  localparam int BANK_LSB = 2 + NUM_PINS;

  logic data_wr;
  assign data_wr = req_valid && req_write && (req_addr[BANK_LSB+1:BANK_LSB] == 2'd0);

  AST_RESET_CLEAN: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (pin_out == '0 && pin_oe == '0 && !irq)); // R4

  AST_DATA_HOLD: assert property (@(posedge clk) disable iff (rst)
    !data_wr |=> $stable(pin_out)); // R1

  AST_MASKED_WRITE: assert property (@(posedge clk) disable iff (rst)
    data_wr |=> (((pin_out ^ $past(pin_out)) & ~$past(req_addr[BANK_LSB-1:2])) == '0)); // R1

  AST_IRQ_CAUSE: assert property (@(posedge clk) disable iff (rst)
    irq |-> $past(|ena_q)); // R8

  AST_CLEAR_TAKES: assert property (@(posedge clk) disable iff (rst)
    (|clr_bits) |=> ((edge_st & $past(clr_bits & ~evt)) == '0)); // R9

  AST_EDGE_WINS: assert property (@(posedge clk) disable iff (rst)
    (|evt) |=> ((edge_st & $past(evt)) == $past(evt))); // R10
endmodule

bind gpio_bank gpio_bank_chk #(.NUM_PINS(NUM_PINS), .ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst(rst), .req_valid(req_valid), .req_write(req_write),
  .req_addr(req_addr), .pin_out(pin_out), .pin_oe(pin_oe), .irq(irq),
  .ena_q(ena_q), .clr_bits(clr_bits), .evt(evt), .edge_st(edge_st)
);

// File: tb/test_gpio_bank.sv
`timescale 1ns/1ps
module test_gpio_bank;
  localparam int NP = 8;
  localparam logic [11:0] A_OUTEN = 12'h400, A_SENSE = 12'h404, A_BOTH = 12'h408,
                          A_POL = 12'h40C, A_ENA = 12'h410, A_RAW = 12'h414,
                          A_MSK = 12'h418, A_CLR = 12'h41C;

  logic clk = 1'b0, rst = 1'b1;
  logic req_valid = 1'b0, req_write = 1'b0;
  logic [11:0] req_addr = '0;
  logic [31:0] req_wdata = '0, rd_data;
  logic [NP-1:0] pin_in = '0, pin_out, pin_oe;
  logic irq;

  int checks = 0, errors = 0;
  bit finished = 0;

  logic [NP-1:0] m_data, m_outen, m_sense, m_both, m_pol, m_ena, m_edge, m_pins;

  always #2.5 clk = ~clk;

  gpio_bank i_gpio_bank (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata), .rd_data(rd_data),
    .pin_in(pin_in), .pin_out(pin_out), .pin_oe(pin_oe), .irq(irq)
  );

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [NP-1:0] exp_view(logic [NP-1:0] mask);
    return ((m_outen & m_data) | (~m_outen & m_pins)) & mask;
  endfunction

  function automatic logic [NP-1:0] exp_raw();
    logic [NP-1:0] r;
    for (int i = 0; i < NP; i++)
      r[i] = m_sense[i] ? (m_pol[i] ? m_pins[i] : ~m_pins[i]) : m_edge[i];
    return r;
  endfunction

  function automatic void model_pins(logic [NP-1:0] nv);
    logic [NP-1:0] rise, fall, ev;
    rise = nv & ~m_pins;
    fall = ~nv & m_pins;
    for (int i = 0; i < NP; i++)
      ev[i] = ~m_sense[i] & (m_both[i] ? (rise[i] | fall[i])
                                       : (m_pol[i] ? rise[i] : fall[i]));
    m_edge |= ev;
    m_pins = nv;
  endfunction

  task automatic bus_write(logic [11:0] a, logic [31:0] d);
    @(negedge clk);
    req_valid = 1'b1; req_write = 1'b1; req_addr = a; req_wdata = d;
    @(posedge clk);
    @(negedge clk);
    req_valid = 1'b0; req_write = 1'b0;
    if (a[11:10] == 2'd0) begin
      for (int i = 0; i < NP; i++) if (a[2+i]) m_data[i] = d[i];
    end else begin
      case (a)
        A_OUTEN: m_outen = d[NP-1:0];
        A_SENSE: m_sense = d[NP-1:0];
        A_BOTH:  m_both  = d[NP-1:0];
        A_POL:   m_pol   = d[NP-1:0];
        A_ENA:   m_ena   = d[NP-1:0];
        A_CLR:   m_edge  = m_edge & ~d[NP-1:0];
        default: ;
      endcase
    end
  endtask

  task automatic bus_read(logic [11:0] a, output logic [31:0] d);
    @(negedge clk);
    req_valid = 1'b1; req_write = 1'b0; req_addr = a;
    @(posedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    d = rd_data;
  endtask

  task automatic drive_pins(logic [NP-1:0] nv);
    @(negedge clk);
    pin_in = nv;
    model_pins(nv);
    repeat (4) @(posedge clk);
  endtask

  task automatic check_status(string tag);
    logic [31:0] d;
    bus_read(A_RAW, d);
    check({tag, " raw"}, d, {24'h0, exp_raw()});
    bus_read(A_MSK, d);
    check({tag, " masked"}, d, {24'h0, exp_raw() & m_ena});
    @(negedge clk);
    check({tag, " irq"}, {31'h0, irq}, {31'h0, |(exp_raw() & m_ena)});
  endtask

  initial begin
    repeat (40000) @(posedge clk);
    if (!finished) begin
      errors++; checks++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [31:0] d;
    void'($urandom(32'h5eed_1234));
    m_data = '0; m_outen = '0; m_sense = '0; m_both = '0; m_pol = '0;
    m_ena = '0; m_edge = '0; m_pins = '0;
    repeat (3) @(posedge clk);
    @(negedge clk); rst = 1'b0;

    // R4 reset state
    check("R4 pin_out", {24'h0, pin_out}, 32'h0);
    check("R4 pin_oe", {24'h0, pin_oe}, 32'h0);
    check("R4 irq", {31'h0, irq}, 32'h0);
    check("R4 rd_data", rd_data, 32'h0);
    bus_read(A_SENSE, d); check("R4 sense", d, 32'h0);
    bus_read(A_ENA, d);   check("R4 enable", d, 32'h0);

    // R1 masked write, R3 direction
    bus_write(A_OUTEN, 32'hFF);
    check("R3 pin_oe", {24'h0, pin_oe}, 32'hFF);
    bus_write(12'h3FC, 32'hA5);
    check("R1 full write", {24'h0, pin_out}, 32'hA5);
    bus_write(12'h00C, 32'h00);  // mask lines 0,1
    check("R1 masked write", {24'h0, pin_out}, 32'hA4);
    bus_write(A_SENSE, 32'hFF);  // other bank
    check("R1 other bank no effect", {24'h0, pin_out}, 32'hA4);
    bus_write(A_SENSE, 32'h00);
    // R2 masked read
    bus_read(12'h0F0, d); check("R2 masked read", d, {24'h0, exp_view(8'h3C)});
    // R3 input lines show pins
    bus_write(A_OUTEN, 32'h0F);
    drive_pins(8'h5A);
    bus_read(12'h3FC, d); check("R3 mixed read", d, {24'h0, exp_view(8'hFF)});

    // R11 synchronizer latency
    bus_write(A_OUTEN, 32'h00);
    @(negedge clk);
    pin_in = 8'hC3;
    req_valid = 1'b1; req_write = 1'b0; req_addr = 12'h3FC;
    @(posedge clk); @(negedge clk);
    req_valid = 1'b0;
    check("R11 old value first edge", rd_data, {24'h0, m_pins});
    model_pins(8'hC3);
    repeat (4) @(posedge clk);
    bus_read(12'h3FC, d); check("R11 new value later", d, 32'hC3);

    // R5 level detect, both polarities
    bus_write(A_CLR, 32'hFF);
    bus_write(A_SENSE, 32'h03); bus_write(A_POL, 32'h01); bus_write(A_ENA, 32'h01);
    drive_pins(8'h01);
    check_status("R5 level high");
    drive_pins(8'h00);
    check_status("R5 level dropped");

    // R6 single edge rising / falling
    bus_write(A_SENSE, 32'h00); bus_write(A_POL, 32'h04); bus_write(A_ENA, 32'h0C);
    bus_write(A_CLR, 32'hFF);
    drive_pins(8'h0C);   // rise on 2,3 -> only line2 (pol 1)
    check_status("R6 rise");
    drive_pins(8'h00);   // fall on 2,3 -> line3 (pol 0)
    check_status("R6 fall latched");
    // R9 clear with zeros has no effect, ones clears
    bus_write(A_CLR, 32'h00);
    check_status("R9 clear zero");
    bus_write(A_CLR, 32'h04);
    check_status("R9 clear one");
    bus_read(A_CLR, d); check("R9 clear reads zero", d, 32'h0);
    // R7 both edges ignore polarity
    bus_write(A_CLR, 32'hFF);
    bus_write(A_BOTH, 32'h30); bus_write(A_POL, 32'h00);
    drive_pins(8'h10);
    check_status("R7 both rise");
    bus_write(A_CLR, 32'hFF);
    drive_pins(8'h00);
    check_status("R7 both fall");
    // R8 enable gates irq
    bus_write(A_ENA, 32'h00);
    check_status("R8 disabled");

    // R10 edge coinciding with clear
    bus_write(A_BOTH, 32'h00); bus_write(A_POL, 32'h01); bus_write(A_ENA, 32'h01);
    bus_write(A_CLR, 32'hFF);
    @(negedge clk);
    pin_in = 8'h01;
    @(posedge clk); @(posedge clk);
    @(negedge clk);
    req_valid = 1'b1; req_write = 1'b1; req_addr = A_CLR; req_wdata = 32'h01;
    @(posedge clk); @(negedge clk);
    req_valid = 1'b0; req_write = 1'b0;
    m_pins = 8'h01; m_edge = 8'h01;
    check_status("R10 edge wins");
    bus_write(A_CLR, 32'h01);
    check_status("R10 later clear");

    // Constrained random mix
    for (int it = 0; it < 300; it++) begin
      int op = $urandom_range(0, 6);
      logic [11:0] a;
      case (op)
        0: begin a = {2'b00, 8'($urandom), 2'b00}; bus_write(a, $urandom); end
        1: bus_write(A_OUTEN, $urandom);
        2: begin
             a = {2'b00, 8'($urandom), 2'b00};
             bus_read(a, d); check("R2 R3 random read", d, {24'h0, exp_view(a[9:2])});
           end
        3: drive_pins(8'($urandom));
        4: begin
             case ($urandom_range(0, 3))
               0: bus_write(A_SENSE, $urandom);
               1: bus_write(A_BOTH, $urandom);
               2: bus_write(A_POL, $urandom);
               default: bus_write(A_ENA, $urandom);
             endcase
           end
        5: bus_write(A_CLR, $urandom);
        default: check_status("R5 R6 R7 R8 random status");
      endcase
      @(negedge clk);
      check("R1 random pin_out", {24'h0, pin_out}, {24'h0, m_data});
    end

    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule